// File: doc/BRIEF.md
# Three-Wire Serial Control Register Bank

This block is the write-only configuration store of a frequency synthesizer. A host shifts 24-bit words in over a three-wire serial link made of a serial clock, a data line and a latch strobe. All three lines are sampled by the block's own system clock through synchronizer stages. When the latch strobe rises, the word held in the shift register is written into one of six control registers. The target register is chosen by a prefix code of variable length in the word's low bits. The bank decodes the stored words into the control fields that the rest of the synthesizer consumes: the RF divider settings, the section enables gated by a chip-enable pin, the output power, the IF charge-pump current, the loop-bandwidth controls and the IF counter values.

A default-select bit in the first register chooses where the IF counters come from. When it is set, a 2-bit IF select and a reference select pick preset divider values. When it is clear, the user registers supply them. A seventh code is accepted on the link and changes no output.

The front end is a three-state machine. ST_LOAD waits with the latch low while serial clock edges shift data in. Its LOAD-to-COMMIT transition fires on a latch rising edge. ST_COMMIT lasts exactly one cycle and writes the word. From there the machine goes to ST_HELD if the latch is still high, or back to ST_LOAD if it is already low. ST_HELD returns to ST_LOAD once the latch falls.

Top module: `serial_cfg_bank`

## Requirements
- R1: Each synchronized rising edge of ser_clk shifts ser_data into bit 0 of a 24-bit shift register, and the older bits move toward bit 23. Only the last 24 bits shifted before a commit matter, so the first bit sent ends up as bit 23.
- R2: A rising edge of ser_latch commits the shift register exactly once. Serial clock edges while the latch stays high shift data but commit nothing. The next commit needs the latch to fall and rise again.
- R3: The target is decoded from the low bits of the word. Bits[1:0]=00 selects register 0, 01 selects register 1 and 10 selects register 2. Bits[2:0]=011 selects register 3, bits[3:0]=0111 register 4, bits[4:0]=01111 register 5 and bits[5:0]=011111 register 6. Register 0 holds default-select at bit 23, path select at 22, lock-detect enable at 21, spur control at 20, rf_b at [19:16], rf_a at [15:13] and rf_fn at [12:2].
- R4: Register 1 holds the IF select at [23:22], the reference select at 21, the output power at [7:6], the RF enable at 3 and the IF enable at 2. With chip_en high, rf_on follows the RF enable and if_on follows the IF enable.
- R5: Register 2 holds the charge-pump code at [23:22]. cp_ua reads 100 for code 00, 200 for code 01, 300 for code 10 and 800 for code 11.
- R6: When chip_en is low, rf_on and if_on are both 0, whatever the register contents.
- R7: A word carrying the register-6 code, or low bits 111111 (no code), is accepted and leaves every output unchanged.
- R8: With default-select at 1, the IF select picks (if_b, if_a) as follows: 00 gives (88, 15), 01 gives (191, 4), and 10 or 11 give (229, 9). if_r is 160 when the reference select is 0 and 164 when it is 1.
- R9: Register 4 holds if_a at [20:17] and if_b at [16:8]. Register 5 holds if_r at [13:5]. These values drive the IF outputs only while default-select is 0. Writing them while default-select is 1 changes no output.
- R10: Reset loads the default words. Default-select, path select and lock-detect enable are 1, spur control is 0, and rf_b, rf_a, rf_fn are 11, 4, 1104. The IF select is 10, the reference select 0, the output power 11, and both enables are 1. The charge-pump code is 10. Bandwidth duration and criterion are 00, bandwidth enable is 1 and the VCO current is 11. User IF values are 229, 9 and 160.
- R11: Register 3 holds the bandwidth duration at [23:22], the bandwidth criterion at [21:20], the bandwidth enable at 19 and the VCO current at [4:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Latch strobe, commits on rising edge |
| chip_en | input | 1 | Chip enable; low forces both sections off |
| use_defaults | output | 1 | Default-select bit |
| path_sel | output | 1 | RF path select |
| lock_det_en | output | 1 | Lock-detect output enable |
| spur_ctl | output | 1 | Spur control bit |
| rf_b | output | 4 | RF programmable counter value |
| rf_a | output | 3 | RF swallow counter value |
| rf_fn | output | 11 | RF fractional numerator |
| rf_on | output | 1 | RF section active |
| if_on | output | 1 | IF section active |
| out_pwr | output | 2 | RF output power code |
| ref_sel | output | 1 | Reference frequency select |
| cp_code | output | 2 | IF charge-pump code |
| cp_ua | output | 10 | IF charge-pump current in microamps |
| bw_dur | output | 2 | Bandwidth control duration |
| bw_crit | output | 2 | Bandwidth phase criterion |
| bw_en | output | 1 | Bandwidth control enable |
| vco_cur | output | 2 | VCO dynamic current code |
| if_b | output | 9 | Effective IF programmable counter |
| if_a | output | 4 | Effective IF swallow counter |
| if_r | output | 9 | Effective IF reference divider |

## Verification
If the shift register or the address decode goes wrong, the wrong field moves when the latch rises, a few system cycles after the strobe is synchronized. It can also show as a register that should have been left alone changing instead. A front-end state machine stuck in ST_HELD shows up as a commit that never lands. A double commit is invisible at the ports unless the shift register moved in between, which is why the single-commit rule is guarded in the RTL. A wrong default-select path shows as IF counters that do or do not follow registers 4 and 5. The same holds for the register-6 and no-match codes, which must leave every output as it was.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int WORD_W = 24;
    localparam int NREG   = 6;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_COMMIT,
        ST_HELD
    } fe_state_t;

    typedef enum logic [2:0] {
        SEL_R0, SEL_R1, SEL_R2, SEL_R3, SEL_R4, SEL_R5, SEL_R6, SEL_NONE
    } reg_sel_t;

    // preset IF counter values
    localparam logic [8:0] DEF_B_C0 = 9'd88;
    localparam logic [3:0] DEF_A_C0 = 4'd15;
    localparam logic [8:0] DEF_B_C1 = 9'd191;
    localparam logic [3:0] DEF_A_C1 = 4'd4;
    localparam logic [8:0] DEF_B_C2 = 9'd229;
    localparam logic [3:0] DEF_A_C2 = 4'd9;
    localparam logic [8:0] DEF_R_LO = 9'd160;
    localparam logic [8:0] DEF_R_HI = 9'd164;

    // prefix-code address decode (R3)
    function automatic reg_sel_t decode_addr(input logic [5:0] lo);
        reg_sel_t s;
        casez (lo)
            6'b????00: s = SEL_R0;
            6'b????01: s = SEL_R1;
            6'b????10: s = SEL_R2;
            6'b???011: s = SEL_R3;
            6'b??0111: s = SEL_R4;
            6'b?01111: s = SEL_R5;
            6'b011111: s = SEL_R6;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    // reset words (R10)
    function automatic logic [WORD_W-1:0] default_word(input int idx);
        logic [WORD_W-1:0] w;
        case (idx)
            0:       w = {1'b1, 1'b1, 1'b1, 1'b0, 4'd11, 3'd4, 11'd1104, 2'b00};
            1:       w = {2'b10, 1'b0, 13'd0, 2'b11, 2'b00, 1'b1, 1'b1, 2'b01};
            2:       w = {2'b10, 20'd0, 2'b10};
            3:       w = {2'b00, 2'b00, 1'b1, 14'd0, 2'b11, 3'b011};
            4:       w = {3'd0, 4'd9, 9'd229, 4'd0, 4'b0111};
            default: w = {10'd0, 9'd160, 5'b01111};
        endcase
        return w;
    endfunction

    // charge-pump code to microamps (R5)
    function automatic logic [9:0] cp_code_to_ua(input logic [1:0] code);
        logic [9:0] ua;
        unique case (code)
            2'b00: ua = 10'd100;
            2'b01: ua = 10'd200;
            2'b10: ua = 10'd300;
            2'b11: ua = 10'd800;
        endcase
        return ua;
    endfunction

endpackage

// File: rtl/ser_front.sv
module ser_front
    import cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SR_W        = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_clk,
    input  logic            ser_data,
    input  logic            ser_latch,
    output logic            commit,
    output logic [SR_W-1:0] word
);

    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0]      clk_pipe;
    logic [PIPE_W-1:0]      le_pipe;
    logic [SYNC_STAGES-1:0] dat_pipe;
    logic                   clk_rise;
    logic                   le_rise;
    logic                   le_high;
    logic                   data_s;
    fe_state_t              state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_pipe <= '0;
            le_pipe  <= '0;
            dat_pipe <= '0;
        end else begin
            clk_pipe <= {clk_pipe[PIPE_W-2:0], ser_clk};
            le_pipe  <= {le_pipe[PIPE_W-2:0], ser_latch};
            dat_pipe <= {dat_pipe[SYNC_STAGES-2:0], ser_data};
        end
    end

    assign clk_rise = clk_pipe[SYNC_STAGES-1] & ~clk_pipe[SYNC_STAGES];
    assign le_rise  = le_pipe[SYNC_STAGES-1]  & ~le_pipe[SYNC_STAGES];
    assign le_high  = le_pipe[SYNC_STAGES-1];
    assign data_s   = dat_pipe[SYNC_STAGES-1];

    // shift register, MSB first (R1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (clk_rise) begin
            word <= {word[SR_W-2:0], data_s};
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // next state (R2)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:   if (le_rise) state_d = ST_COMMIT;
            ST_COMMIT: state_d = le_high ? ST_HELD : ST_LOAD;
            ST_HELD:   if (!le_high) state_d = ST_LOAD;
            default:   state_d = ST_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        commit = (state_q == ST_COMMIT);
    end

    p_shift_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clk_rise |=> word == {$past(word[SR_W-2:0]), $past(data_s)});

    p_commit_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    p_commit_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(le_rise));

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import cfg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit,
    input  logic [WORD_W-1:0]           word,
    output logic [NREG-1:0][WORD_W-1:0] regs_q
);

    reg_sel_t sel;

    assign sel = decode_addr(word[5:0]);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam reg_sel_t MY_SEL = reg_sel_t'(3'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= default_word(g);
            end else if (commit && sel == MY_SEL) begin
                regs_q[g] <= word;
            end
        end
    end

    p_ignore_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (sel == SEL_R6 || sel == SEL_NONE)) |=> $stable(regs_q));

    p_r0_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sel == SEL_R0) |=> regs_q[0] == $past(word));

endmodule

// File: rtl/if_select.sv
module if_select
    import cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       use_def,
    input  logic [1:0] if_sel,
    input  logic       ref_sel,
    input  logic [8:0] user_b,
    input  logic [3:0] user_a,
    input  logic [8:0] user_r,
    output logic [8:0] eff_b,
    output logic [3:0] eff_a,
    output logic [8:0] eff_r
);

    logic [8:0] pre_b;
    logic [3:0] pre_a;
    logic [8:0] pre_r;

    always_comb begin
        unique case (if_sel)
            2'b00:   begin pre_b = DEF_B_C0; pre_a = DEF_A_C0; end
            2'b01:   begin pre_b = DEF_B_C1; pre_a = DEF_A_C1; end
            default: begin pre_b = DEF_B_C2; pre_a = DEF_A_C2; end
        endcase
        pre_r = ref_sel ? DEF_R_HI : DEF_R_LO;
    end

    assign eff_b = use_def ? pre_b : user_b;
    assign eff_a = use_def ? pre_a : user_a;
    assign eff_r = use_def ? pre_r : user_r;

    p_def_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        use_def |-> (eff_r == DEF_R_LO || eff_r == DEF_R_HI));

    p_user_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !use_def |-> (eff_b == user_b && eff_r == user_r));

endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank
    import cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_data,
    input  logic        ser_latch,
    input  logic        chip_en,
    output logic        use_defaults,
    output logic        path_sel,
    output logic        lock_det_en,
    output logic        spur_ctl,
    output logic [3:0]  rf_b,
    output logic [2:0]  rf_a,
    output logic [10:0] rf_fn,
    output logic        rf_on,
    output logic        if_on,
    output logic [1:0]  out_pwr,
    output logic        ref_sel,
    output logic [1:0]  cp_code,
    output logic [9:0]  cp_ua,
    output logic [1:0]  bw_dur,
    output logic [1:0]  bw_crit,
    output logic        bw_en,
    output logic [1:0]  vco_cur,
    output logic [8:0]  if_b,
    output logic [3:0]  if_a,
    output logic [8:0]  if_r
);

    logic                        commit;
    logic [WORD_W-1:0]           word;
    logic [NREG-1:0][WORD_W-1:0] regs_q;
    logic [WORD_W-1:0]           r0, r1, r2, r3, r4, r5;
    logic                        unused_bits;

    ser_front #(
        .SYNC_STAGES (SYNC_STAGES),
        .SR_W        (WORD_W)
    ) i_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_latch (ser_latch),
        .commit    (commit),
        .word      (word)
    );

    cfg_regs i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .word   (word),
        .regs_q (regs_q)
    );

    assign r0 = regs_q[0];
    assign r1 = regs_q[1];
    assign r2 = regs_q[2];
    assign r3 = regs_q[3];
    assign r4 = regs_q[4];
    assign r5 = regs_q[5];

    // register 0 fields (R3)
    assign use_defaults = r0[23];
    assign path_sel     = r0[22];
    assign lock_det_en  = r0[21];
    assign spur_ctl     = r0[20];
    assign rf_b         = r0[19:16];
    assign rf_a         = r0[15:13];
    assign rf_fn        = r0[12:2];

    // register 1 fields and chip-enable gating (R4, R6)
    assign ref_sel = r1[21];
    assign out_pwr = r1[7:6];
    assign rf_on   = chip_en & r1[3];
    assign if_on   = chip_en & r1[2];

    // register 2 (R5)
    assign cp_code = r2[23:22];
    assign cp_ua   = cp_code_to_ua(cp_code);

    // register 3 (R11)
    assign bw_dur  = r3[23:22];
    assign bw_crit = r3[21:20];
    assign bw_en   = r3[19];
    assign vco_cur = r3[4:3];

    if_select i_ifsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .use_def (use_defaults),
        .if_sel  (r1[23:22]),
        .ref_sel (r1[21]),
        .user_b  (r4[16:8]),
        .user_a  (r4[20:17]),
        .user_r  (r5[13:5]),
        .eff_b   (if_b),
        .eff_a   (if_a),
        .eff_r   (if_r)
    );

    assign unused_bits = ^{r0[1:0], r1[20:8], r1[5:4], r1[1:0], r2[21:0],
                           r3[18:5], r3[2:0], r4[23:21], r4[7:0],
                           r5[23:14], r5[4:0]};

    p_ce_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> (!rf_on && !if_on));

endmodule

// File: tb/test_serial_cfg_bank.sv
module test_serial_cfg_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 21;

    // word, probe id, expected value, requirement number
    typedef struct packed {
        logic [23:0] word;
        logic [3:0]  probe;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    // probes: 0 rf_b, 1 rf_a, 2 rf_fn, 3 {path,ld,spur}, 4 {rf_on,if_on},
    // 5 out_pwr, 6 cp_ua, 7 {bw_dur,bw_crit,bw_en,vco_cur}, 8 if_b, 9 if_a, 10 if_r
    localparam vec_t [0:NVEC-1] VECS = '{
        // R3 register-0 fields
        {{1'b1,1'b0,1'b1,1'b1,4'd7,3'd2,11'd1500,2'b00},        4'd0,  16'd7,    4'd3},
        {{1'b1,1'b1,1'b0,1'b0,4'd15,3'd7,11'd2047,2'b00},       4'd1,  16'd7,    4'd3},
        {{1'b1,1'b0,1'b1,1'b1,4'd2,3'd0,11'd1,2'b00},           4'd3,  16'd3,    4'd3},
        {{1'b1,1'b1,1'b1,1'b0,4'd5,3'd3,11'd1967,2'b00},        4'd2,  16'd1967, 4'd3},
        // R5 charge pump
        {{2'b00,20'd0,2'b10},                                   4'd6,  16'd100,  4'd5},
        {{2'b01,20'd0,2'b10},                                   4'd6,  16'd200,  4'd5},
        {{2'b10,20'd0,2'b10},                                   4'd6,  16'd300,  4'd5},
        {{2'b11,20'd0,2'b10},                                   4'd6,  16'd800,  4'd5},
        // R11 bandwidth fields
        {{2'b10,2'b01,1'b0,14'd0,2'b11,3'b011},                 4'd7,  16'd75,   4'd11},
        // R4 enables
        {{2'b00,1'b1,13'd0,2'b01,2'b00,1'b1,1'b0,2'b01},        4'd4,  16'd2,    4'd4},
        // R8 presets
        {{2'b00,1'b1,13'd0,2'b01,2'b00,1'b1,1'b1,2'b01},        4'd8,  16'd88,   4'd8},
        {{2'b00,1'b1,13'd0,2'b01,2'b00,1'b1,1'b1,2'b01},        4'd10, 16'd164,  4'd8},
        {{2'b01,1'b0,13'd0,2'b01,2'b00,1'b1,1'b1,2'b01},        4'd9,  16'd4,    4'd8},
        {{2'b01,1'b0,13'd0,2'b01,2'b00,1'b1,1'b1,2'b01},        4'd10, 16'd160,  4'd8},
        // R9 user IF values ignored, then used
        {{3'd0,4'd3,9'd300,4'd0,4'b0111},                       4'd8,  16'd191,  4'd9},
        {{10'd0,9'd77,5'b01111},                                4'd10, 16'd160,  4'd9},
        {{1'b0,1'b0,1'b0,1'b0,4'd9,3'd1,11'd5,2'b00},           4'd8,  16'd300,  4'd9},
        // R7 ignored codes
        {{18'h3FFFF,6'b011111},                                 4'd10, 16'd77,   4'd7},
        {{18'h3FFFF,6'b111111},                                 4'd0,  16'd9,    4'd7},
        // R4 output power
        {{2'b10,1'b0,13'd0,2'b10,2'b00,1'b1,1'b1,2'b01},        4'd5,  16'd2,    4'd4},
        // R9 if_a from user register
        {{2'b11,20'd0,2'b10},                                   4'd9,  16'd3,    4'd9}
    };

    logic        clk;
    logic        rst_n;
    logic        ser_clk;
    logic        ser_data;
    logic        ser_latch;
    logic        chip_en;
    logic        use_defaults, path_sel, lock_det_en, spur_ctl;
    logic [3:0]  rf_b;
    logic [2:0]  rf_a;
    logic [10:0] rf_fn;
    logic        rf_on, if_on;
    logic [1:0]  out_pwr;
    logic        ref_sel;
    logic [1:0]  cp_code;
    logic [9:0]  cp_ua;
    logic [1:0]  bw_dur, bw_crit;
    logic        bw_en;
    logic [1:0]  vco_cur;
    logic [8:0]  if_b;
    logic [3:0]  if_a;
    logic [8:0]  if_r;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    serial_cfg_bank i_serial_cfg_bank (
        .clk (clk), .rst_n (rst_n), .ser_clk (ser_clk), .ser_data (ser_data),
        .ser_latch (ser_latch), .chip_en (chip_en),
        .use_defaults (use_defaults), .path_sel (path_sel),
        .lock_det_en (lock_det_en), .spur_ctl (spur_ctl),
        .rf_b (rf_b), .rf_a (rf_a), .rf_fn (rf_fn),
        .rf_on (rf_on), .if_on (if_on), .out_pwr (out_pwr), .ref_sel (ref_sel),
        .cp_code (cp_code), .cp_ua (cp_ua),
        .bw_dur (bw_dur), .bw_crit (bw_crit), .bw_en (bw_en), .vco_cur (vco_cur),
        .if_b (if_b), .if_a (if_a), .if_r (if_r)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int probe_val(input logic [3:0] id);
        case (id)
            4'd0:    return 32'(rf_b);
            4'd1:    return 32'(rf_a);
            4'd2:    return 32'(rf_fn);
            4'd3:    return 32'({path_sel, lock_det_en, spur_ctl});
            4'd4:    return 32'({rf_on, if_on});
            4'd5:    return 32'(out_pwr);
            4'd6:    return 32'(cp_ua);
            4'd7:    return 32'({bw_dur, bw_crit, bw_en, vco_cur});
            4'd8:    return 32'(if_b);
            4'd9:    return 32'(if_a);
            default: return 32'(if_r);
        endcase
    endfunction

    task automatic check(input int req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b;
        wait_clks(3);
        ser_clk = 1'b1;
        wait_clks(3);
        ser_clk = 1'b0;
    endtask

    task automatic shift_word(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic pulse_latch();
        wait_clks(3);
        ser_latch = 1'b1;
        wait_clks(6);
        ser_latch = 1'b0;
        wait_clks(6);
    endtask

    initial begin
        wait_clks(200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ser_clk = 1'b0;
        ser_data = 1'b0;
        ser_latch = 1'b0;
        chip_en = 1'b1;
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(2);
        @(negedge clk);

        // R10 reset state
        check(10, "reset rf_b", probe_val(4'd0), 11);
        check(10, "reset rf_fn", probe_val(4'd2), 1104);
        check(10, "reset if_b", probe_val(4'd8), 229);
        check(10, "reset if_r", probe_val(4'd10), 160);
        check(10, "reset cp_ua", probe_val(4'd6), 300);
        check(10, "reset bw", probe_val(4'd7), 7'b0000111);
        check(10, "reset enables", probe_val(4'd4), 3);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            shift_word(VECS[v].word);
            pulse_latch();
            @(negedge clk);
            check(int'(VECS[v].req), $sformatf("vector %0d", v),
                  probe_val(VECS[v].probe), int'(VECS[v].exp));
        end

        // R6 chip enable low forces off, then R4 released
        chip_en = 1'b0;
        @(negedge clk);
        check(6, "chip_en low", probe_val(4'd4), 0);
        chip_en = 1'b1;
        @(negedge clk);
        check(4, "chip_en high", probe_val(4'd4), 3);

        // R1 extra leading bits fall off the top
        for (int i = 0; i < 4; i++) shift_bit(1'b1);
        shift_word({2'b00, 20'd0, 2'b10});
        pulse_latch();
        @(negedge clk);
        check(1, "leading bits dropped", probe_val(4'd6), 100);

        // R2 clocks while latch high do not commit; next rise does
        wait_clks(3);
        ser_latch = 1'b1;
        wait_clks(6);
        shift_word({2'b01, 20'd0, 2'b10});
        wait_clks(6);
        @(negedge clk);
        check(2, "no commit while latch high", probe_val(4'd6), 100);
        ser_latch = 1'b0;
        wait_clks(6);
        @(negedge clk);
        check(2, "latch fall no commit", probe_val(4'd6), 100);
        pulse_latch();
        @(negedge clk);
        check(2, "next rise commits", probe_val(4'd6), 200);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule